// File: doc/BRIEF.md
# Synchronous Burst SRAM with Byte-Lane Writes

This block models a single-ported synchronous static RAM that moves data in short bursts. A memory word is made of four byte lanes, and each lane holds eight data bits plus one parity bit. On every rising clock edge the control logic looks at two address-start strobes, an advance input and the write controls. From these it decides what the edge does: start a new access at the presented address, step to the next address of the running burst, or hold the burst on its current address. It also decides whether that access reads or writes.

One start strobe always begins a read. The second start strobe begins a write when the write controls ask for one. A two-bit burst counter steps linearly and wraps inside an aligned block of four words. A write can store the whole word or only the lanes that are selected. Read data is registered. The data-driver enable is gated by an output-enable input that is not clocked, and it is forced off during write cycles and while the device is deselected. Three chip-select inputs qualify every start.

Top module: `burst_sram`

## Requirements
- R1: A start strobe sampled with `sel_a_n` low, `sel_b` high and `sel_c_n` low begins an access. A start sampled with any other select combination deselects the device. While the device is deselected, `data_oe` stays low and advance or hold edges neither read nor write, until the next qualified start.
- R2: A qualified edge with `start_rd_n` low loads `addr` and performs a read, whatever the values of `all_wr_n`, `lane_wr_en_n` and `lane_sel_n`.
- R3: A qualified edge with `start_rd_n` high and `start_any_n` low loads `addr`. It writes when the write condition holds and reads otherwise. When both strobes are low, `start_rd_n` takes priority and the edge reads.
- R4: The write condition is true when `all_wr_n` is low, or when `lane_wr_en_n` is low and at least one `lane_sel_n` bit is low. With `lane_wr_en_n` low and all four `lane_sel_n` bits high, the cycle is a read.
- R5: With `all_wr_n` high and `lane_wr_en_n` low, lane i writes only when `lane_sel_n[i]` is low. Lane i occupies bits 9i+8 down to 9i, with the parity bit on top. Unselected lanes keep their contents. With `all_wr_n` low, all four lanes are written.
- R6: With `all_wr_n` and `lane_wr_en_n` both high, the cycle is a read, whatever the `lane_sel_n` bits are.
- R7: On an edge with both strobes high, an active burst and `step_n` low, the access moves to the next address. The two low address bits count up by one and wrap from 3 to 0, and the upper bits are held.
- R8: On an edge with both strobes high, an active burst and `step_n` high, the access reuses the current address for the read or the write.
- R9: Read data is captured at the edge that performs the read and is presented on `data_out` right after that edge.
- R10: `data_oe` is high only when the last edge performed a read and `out_en_n` is low. It follows `out_en_n` combinationally, with no clock edge needed.
- R11: After an edge that performs a write, `data_oe` is low even when `out_en_n` is low.
- R12: Synchronous reset `rst` ends any burst and turns `data_oe` off. After reset, advance or hold edges do not write until a qualified start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| sel_a_n | input | 1 | Chip select, active low |
| sel_b | input | 1 | Chip select, active high |
| sel_c_n | input | 1 | Chip select, active low |
| start_rd_n | input | 1 | Address start that always reads, active low |
| start_any_n | input | 1 | Address start that may read or write, active low |
| step_n | input | 1 | Advance burst when low, hold address when high |
| all_wr_n | input | 1 | Global whole-word write, active low |
| lane_wr_en_n | input | 1 | Enables the per-lane selects, active low |
| lane_sel_n | input | 4 | Per-lane write selects, active low |
| addr | input | 4 | Word address loaded on a start |
| data_in | input | 36 | Write data, four 9-bit lanes |
| out_en_n | input | 1 | Unclocked output enable, active low |
| data_out | output | 36 | Registered read data |
| data_oe | output | 1 | Data-bus driver enable |

## Verification
A wrong burst address does not show on the write edge. It shows only later, when the affected words are read back and a lane holds wrong data, or a word that should be untouched has changed. The bench therefore writes a block, wraps the burst, and reads every word back. A fault in the read/write decode or the select qualification shows one edge after the stimulus, as a wrong level on `data_oe` or a wrong `data_out`. Because the output enable is not clocked, a fault in its gating shows at once, with no clock edge between.

// File: rtl/burst_sram_pkg.sv
package burst_sram_pkg;
    localparam int LANES   = 4;
    localparam int LANE_W  = 9;
    localparam int WORD_W  = LANES * LANE_W;
    localparam int ADDR_W  = 4;
    localparam int BURST_W = 2;
    localparam int DEPTH   = 1 << ADDR_W;

    typedef logic [WORD_W-1:0] word_t;
    typedef logic [ADDR_W-1:0] addr_t;
    typedef logic [LANES-1:0]  lane_mask_t;

    typedef enum logic [1:0] {OP_IDLE, OP_READ, OP_WRITE} op_e;

    typedef struct packed {
        op_e   op;
        addr_t addr;
    } cyc_t;

    // Lanes a write would touch; all zero means the cycle is a read.
    function automatic lane_mask_t lane_mask(input logic all_n, input logic en_n,
                                             input lane_mask_t sel_n);
        if (!all_n)     return '1;
        else if (!en_n) return ~sel_n;
        else            return '0;
    endfunction

    // Linear step inside an aligned block of 2**BURST_W words.
    function automatic addr_t burst_next(input addr_t a);
        addr_t r;
        r = a;
        r[BURST_W-1:0] = a[BURST_W-1:0] + BURST_W'(1);
        return r;
    endfunction
endpackage

// File: rtl/bsram_ctrl.sv
module bsram_ctrl
    import burst_sram_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       sel_ok,
    input  logic       start_rd_n,
    input  logic       start_any_n,
    input  logic       step_n,
    input  lane_mask_t req_mask,
    input  addr_t      addr,
    output cyc_t       cyc,
    output lane_mask_t wr_mask
);
    logic  active_q, active_d;
    addr_t cur_q;
    logic  wr_req;

    assign wr_req = |req_mask;

    always_comb begin
        cyc.op   = OP_IDLE;
        cyc.addr = cur_q;
        active_d = active_q;
        if (!start_rd_n) begin
            active_d = sel_ok;
            if (sel_ok) begin
                cyc.op   = OP_READ;
                cyc.addr = addr;
            end
        end else if (!start_any_n) begin
            active_d = sel_ok;
            if (sel_ok) begin
                cyc.op   = wr_req ? OP_WRITE : OP_READ;
                cyc.addr = addr;
            end
        end else if (active_q) begin
            cyc.op   = wr_req ? OP_WRITE : OP_READ;
            cyc.addr = step_n ? cur_q : burst_next(cur_q);
        end
        wr_mask = (cyc.op == OP_WRITE) ? req_mask : '0;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            active_q <= 1'b0;
            cur_q    <= '0;
        end else begin
            active_q <= active_d;
            if (cyc.op != OP_IDLE) cur_q <= cyc.addr;
        end
    end
endmodule

// File: rtl/bsram_array.sv
module bsram_array
    import burst_sram_pkg::*;
(
    input  logic       clk,
    input  cyc_t       cyc,
    input  lane_mask_t wr_mask,
    input  word_t      din,
    output word_t      rdata
);
    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic [LANE_W-1:0] store [DEPTH];
        logic [LANE_W-1:0] rd_q;

        always_ff @(posedge clk) begin
            if (wr_mask[g]) store[cyc.addr] <= din[g*LANE_W +: LANE_W];
            if (cyc.op == OP_READ) rd_q <= store[cyc.addr];
        end

        assign rdata[g*LANE_W +: LANE_W] = rd_q;
    end
endmodule

// File: rtl/bsram_outstage.sv
module bsram_outstage
    import burst_sram_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  op_e  op,
    input  logic out_en_n,
    output logic data_oe
);
    logic rd_valid_q;

    always_ff @(posedge clk) begin
        if (rst) rd_valid_q <= 1'b0;
        else     rd_valid_q <= (op == OP_READ);
    end

    assign data_oe = rd_valid_q && !out_en_n;
endmodule

// File: rtl/burst_sram.sv
module burst_sram
    import burst_sram_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              sel_a_n,
    input  logic              sel_b,
    input  logic              sel_c_n,
    input  logic              start_rd_n,
    input  logic              start_any_n,
    input  logic              step_n,
    input  logic              all_wr_n,
    input  logic              lane_wr_en_n,
    input  logic [LANES-1:0]  lane_sel_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [WORD_W-1:0] data_in,
    input  logic              out_en_n,
    output logic [WORD_W-1:0] data_out,
    output logic              data_oe
);
    logic       sel_ok;
    lane_mask_t req_mask, wr_mask;
    cyc_t       cyc;

    assign sel_ok   = !sel_a_n && sel_b && !sel_c_n;
    assign req_mask = lane_mask(all_wr_n, lane_wr_en_n, lane_sel_n);

    bsram_ctrl u_ctrl (
        .clk(clk), .rst(rst), .sel_ok(sel_ok),
        .start_rd_n(start_rd_n), .start_any_n(start_any_n), .step_n(step_n),
        .req_mask(req_mask), .addr(addr), .cyc(cyc), .wr_mask(wr_mask)
    );

    bsram_array u_array (
        .clk(clk), .cyc(cyc), .wr_mask(wr_mask), .din(data_in), .rdata(data_out)
    );

    bsram_outstage u_out (
        .clk(clk), .rst(rst), .op(cyc.op), .out_en_n(out_en_n), .data_oe(data_oe)
    );
endmodule

// File: rtl/burst_sram_chk.sv
module burst_sram_chk
    import burst_sram_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              sel_a_n,
    input logic              sel_b,
    input logic              sel_c_n,
    input logic              start_rd_n,
    input logic              start_any_n,
    input logic              step_n,
    input logic              all_wr_n,
    input logic              lane_wr_en_n,
    input logic [LANES-1:0]  lane_sel_n,
    input logic              out_en_n,
    input logic [WORD_W-1:0] data_out,
    input logic              data_oe
);
    logic qual, wants_wr;
    assign qual     = !sel_a_n && sel_b && !sel_c_n;
    assign wants_wr = !all_wr_n || (!lane_wr_en_n && !(&lane_sel_n));

    assert_oe_gate_R10: assert property (@(posedge clk) disable iff (rst)
        out_en_n |-> !data_oe);

    assert_write_blanks_R11: assert property (@(posedge clk) disable iff (rst)
        (start_rd_n && !start_any_n && qual && wants_wr) |=> !data_oe);

    assert_forced_read_R2: assert property (@(posedge clk) disable iff (rst)
        (!start_rd_n && qual) |=> (out_en_n || data_oe));

    assert_deselect_R1: assert property (@(posedge clk) disable iff (rst)
        ((!start_rd_n || !start_any_n) && !qual) |=> !data_oe);

    assert_hold_read_R8: assert property (@(posedge clk) disable iff (rst)
        (data_oe && start_rd_n && start_any_n && step_n && !wants_wr)
            |=> $stable(data_out));
endmodule

bind burst_sram burst_sram_chk u_chk (.*);

// File: tb/burst_sram_test.sv
module burst_sram_test;
    localparam int LW = 9;
    localparam int WW = 36;

    typedef struct packed {
        logic          rd_n;
        logic          any_n;
        logic          sel;
        logic          step;
        logic          gw_n;
        logic          en_n;
        logic [3:0]    bsel_n;
        logic [3:0]    a;
        logic [WW-1:0] din;
        logic          oe_n;
        logic          x_oe;
        logic          chk_d;
        logic [WW-1:0] x_d;
        logic [3:0]    req;
    } vec_t;

    localparam logic [WW-1:0] D1 = {9'h014, 9'h013, 9'h012, 9'h011};
    localparam logic [WW-1:0] D4 = {9'h104, 9'h103, 9'h102, 9'h101};
    localparam logic [WW-1:0] M4 = {9'h104, 9'h103, 9'h102, 9'h1FF};
    localparam logic [WW-1:0] D5 = {9'h054, 9'h053, 9'h052, 9'h051};
    localparam logic [WW-1:0] D6 = {9'h064, 9'h063, 9'h062, 9'h061};
    localparam logic [WW-1:0] D7 = {9'h074, 9'h073, 9'h072, 9'h071};
    localparam logic [WW-1:0] X1 = {9'h0AA, 9'h0BB, 9'h0CC, 9'h0DD};
    localparam logic [WW-1:0] X2 = {9'h001, 9'h002, 9'h003, 9'h0EE};
    localparam logic [WW-1:0] M6 = {9'h0AA, 9'h063, 9'h0CC, 9'h0EE};
    localparam logic [WW-1:0] FF = '1;
    localparam logic [WW-1:0] Z0 = '0;

    localparam int NV = 20;
    localparam vec_t VECS [NV] = '{
        // R3: write start, global write, addr 1
        '{1'b1,1'b0,1'b1,1'b1, 1'b0,1'b1,4'hF, 4'd1, D1, 1'b1, 1'b0,1'b0,Z0, 4'd3},
        // R11: write start at addr 4 with out_en_n low
        '{1'b1,1'b0,1'b1,1'b1, 1'b0,1'b1,4'hF, 4'd4, D4, 1'b0, 1'b0,1'b0,Z0, 4'd11},
        // R7: advance writes to 5, 6, 7
        '{1'b1,1'b1,1'b1,1'b0, 1'b0,1'b1,4'hF, 4'd0, D5, 1'b1, 1'b0,1'b0,Z0, 4'd7},
        '{1'b1,1'b1,1'b1,1'b0, 1'b0,1'b1,4'hF, 4'd0, D6, 1'b1, 1'b0,1'b0,Z0, 4'd7},
        '{1'b1,1'b1,1'b1,1'b0, 1'b0,1'b1,4'hF, 4'd0, D7, 1'b1, 1'b0,1'b0,Z0, 4'd7},
        // R5: wrap to 4, lane 0 only
        '{1'b1,1'b1,1'b1,1'b0, 1'b1,1'b0,4'hE, 4'd0, FF, 1'b1, 1'b0,1'b0,Z0, 4'd5},
        // R2: forced-read start at 4 despite global write
        '{1'b0,1'b1,1'b1,1'b1, 1'b0,1'b1,4'hF, 4'd4, FF, 1'b0, 1'b1,1'b1,M4, 4'd2},
        // R6: advance read, lane enable off, selects low
        '{1'b1,1'b1,1'b1,1'b0, 1'b1,1'b1,4'h0, 4'd0, FF, 1'b0, 1'b1,1'b1,D5, 4'd6},
        // R8: hold, out_en_n high
        '{1'b1,1'b1,1'b1,1'b1, 1'b1,1'b1,4'hF, 4'd0, FF, 1'b1, 1'b0,1'b1,D5, 4'd8},
        // R9: advance read to 6
        '{1'b1,1'b1,1'b1,1'b0, 1'b1,1'b1,4'hF, 4'd0, FF, 1'b0, 1'b1,1'b1,D6, 4'd9},
        '{1'b1,1'b1,1'b1,1'b0, 1'b1,1'b1,4'hF, 4'd0, FF, 1'b0, 1'b1,1'b1,D7, 4'd7},
        // R7: wrap 7 -> 4
        '{1'b1,1'b1,1'b1,1'b0, 1'b1,1'b1,4'hF, 4'd0, FF, 1'b0, 1'b1,1'b1,M4, 4'd7},
        // R1: start with sel_b low
        '{1'b1,1'b0,1'b0,1'b1, 1'b1,1'b1,4'hF, 4'd5, FF, 1'b0, 1'b0,1'b0,Z0, 4'd1},
        // R1: advance with global write while deselected
        '{1'b1,1'b1,1'b1,1'b0, 1'b0,1'b1,4'hF, 4'd0, FF, 1'b0, 1'b0,1'b0,Z0, 4'd1},
        // R1: addr 5 untouched
        '{1'b0,1'b1,1'b1,1'b1, 1'b1,1'b1,4'hF, 4'd5, FF, 1'b0, 1'b1,1'b1,D5, 4'd1},
        // R5: lanes 1 and 3 at addr 6
        '{1'b1,1'b0,1'b1,1'b1, 1'b1,1'b0,4'h5, 4'd6, X1, 1'b0, 1'b0,1'b0,Z0, 4'd5},
        // R8: hold write lane 0
        '{1'b1,1'b1,1'b1,1'b1, 1'b1,1'b0,4'hE, 4'd0, X2, 1'b0, 1'b0,1'b0,Z0, 4'd8},
        // R4: lane enable low, no lane selected -> read
        '{1'b1,1'b0,1'b1,1'b1, 1'b1,1'b0,4'hF, 4'd6, FF, 1'b0, 1'b1,1'b1,M6, 4'd4},
        // R3: both strobes low, forced read wins
        '{1'b0,1'b0,1'b1,1'b1, 1'b0,1'b1,4'hF, 4'd7, FF, 1'b0, 1'b1,1'b1,D7, 4'd3},
        // R6: write start with both enables high -> read
        '{1'b1,1'b0,1'b1,1'b1, 1'b1,1'b1,4'h0, 4'd5, FF, 1'b0, 1'b1,1'b1,D5, 4'd6}
    };

    logic          clk = 1'b0;
    logic          rst;
    logic          sel_a_n, sel_b, sel_c_n;
    logic          start_rd_n, start_any_n, step_n;
    logic          all_wr_n, lane_wr_en_n;
    logic [3:0]    lane_sel_n;
    logic [3:0]    addr;
    logic [WW-1:0] data_in;
    logic          out_en_n;
    logic [WW-1:0] data_out;
    logic          data_oe;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    always #2 clk = ~clk;

    burst_sram uut (
        .clk(clk), .rst(rst), .sel_a_n(sel_a_n), .sel_b(sel_b), .sel_c_n(sel_c_n),
        .start_rd_n(start_rd_n), .start_any_n(start_any_n), .step_n(step_n),
        .all_wr_n(all_wr_n), .lane_wr_en_n(lane_wr_en_n), .lane_sel_n(lane_sel_n),
        .addr(addr), .data_in(data_in), .out_en_n(out_en_n),
        .data_out(data_out), .data_oe(data_oe)
    );

    task automatic check(input string tag, input logic [WW-1:0] act, input logic [WW-1:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic idle_inputs();
        sel_a_n = 1'b0; sel_b = 1'b1; sel_c_n = 1'b0;
        start_rd_n = 1'b1; start_any_n = 1'b1; step_n = 1'b1;
        all_wr_n = 1'b1; lane_wr_en_n = 1'b1; lane_sel_n = 4'hF;
        addr = '0; data_in = '0; out_en_n = 1'b0;
    endtask

    task automatic apply(input vec_t v);
        sel_a_n = 1'b0; sel_b = v.sel; sel_c_n = 1'b0;
        start_rd_n = v.rd_n; start_any_n = v.any_n; step_n = v.step;
        all_wr_n = v.gw_n; lane_wr_en_n = v.en_n; lane_sel_n = v.bsel_n;
        addr = v.a; data_in = v.din; out_en_n = v.oe_n;
    endtask

    initial begin
        #100000;
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        idle_inputs();
        rst = 1'b1;
        repeat (3) @(posedge clk);
        #1 check("R12 oe during reset", {35'd0, data_oe}, '0);
        @(negedge clk) rst = 1'b0;

        for (int i = 0; i < NV; i++) begin
            @(negedge clk) apply(VECS[i]);
            @(posedge clk);
            #1;
            check($sformatf("R%0d vec%0d oe", VECS[i].req, i), {35'd0, data_oe}, {35'd0, VECS[i].x_oe});
            if (VECS[i].chk_d)
                check($sformatf("R%0d vec%0d data", VECS[i].req, i), data_out, VECS[i].x_d);
        end

        // R10: unclocked output enable, no edge between changes
        @(negedge clk) idle_inputs();
        out_en_n = 1'b1;
        #0.5 check("R10 oe follows high", {35'd0, data_oe}, '0);
        out_en_n = 1'b0;
        #0.5 check("R10 oe follows low", {35'd0, data_oe}, 36'd1);

        // R12: reset mid-burst, then advance with global write must not hit addr 1
        @(negedge clk) rst = 1'b1;
        @(posedge clk);
        #1 check("R12 oe after reset", {35'd0, data_oe}, '0);
        @(negedge clk) begin
            rst = 1'b0; step_n = 1'b0; all_wr_n = 1'b0; data_in = FF;
        end
        @(posedge clk);
        #1 check("R12 no burst after reset", {35'd0, data_oe}, '0);
        @(negedge clk) begin
            idle_inputs(); start_rd_n = 1'b0; addr = 4'd1;
        end
        @(posedge clk);
        #1 check("R12 addr1 intact", data_out, D1);
        check("R2 read oe", {35'd0, data_oe}, 36'd1);

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule